// File: doc/BRIEF.md
# Word-to-Serial Transmitter with Internal Wrap

This block turns a stream of pre-encoded 10-bit words into a serial bit stream running at ten times the word rate. A word presented on `tx_word` is registered on the rising edge of the word clock. A bit-domain slot counter then hands it to a shift register at one fixed bit slot. The register emits the word least significant bit first, one bit per bit clock. Consecutive words follow each other with no gap or overlap. The bit clock is supplied as a separate input that is synchronous to the word clock; no clock multiplier is built.

For debugging, a wrap control diverts the serial stream onto an internal loopback output that feeds a companion receiver. While wrap is on, the external line output is held at logic 1. While wrap is off, the line carries the stream and the loopback output rests at 1. Line coding happens upstream. Electrical driver behaviour is outside this block.

Top module: `par2ser_tx`

## Requirements
- R1: `tx_word` is captured only on the rising edge of `word_clk`. A change on `tx_word` between rising edges has no effect on the emitted bits.
- R2: Each captured word occupies exactly ten consecutive bit periods. The first bit of the next word follows the last bit of the previous word directly, one word per word-clock period.
- R3: Bits are emitted least significant first: bit 0 of the word, then bit 1, up to bit 9.
- R4: The slot counter is cleared by reset and advances on every `bit_clk` edge, counting 0 to 9. On the edge where its value is LOAD_SLOT (default 9), the shift register takes the captured word. Bit 0 reaches the outputs on the following `bit_clk` edge.
- R5: Reset (synchronous, active high, applied to both clock domains) fills the shift register and the captured word with ones and drives `line_o` and `loop_o` to 1. The line stays at 1 until the first load.
- R6: While `wrap_en` is 1, `line_o` is held at logic 1.
- R7: While `wrap_en` is 1, `loop_o` carries the serial stream with the same bit order and timing that `line_o` has when wrap is off.
- R8: While `wrap_en` is 0, `line_o` carries the serial stream and `loop_o` is held at 1.
- R9: `wrap_en` is sampled on each `bit_clk` rising edge. A change moves the outputs to the new routing on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_clk | input | 1 | Word-rate reference clock; word capture on rising edge |
| bit_clk | input | 1 | Bit-rate clock, ten edges per word period, synchronous to word_clk |
| rst | input | 1 | Synchronous active-high reset for both domains |
| tx_word | input | 10 | Pre-encoded parallel word, bit 0 sent first |
| wrap_en | input | 1 | 1 routes the stream to loop_o and holds line_o high |
| line_o | output | 1 | External serial line bit, registered |
| loop_o | output | 1 | Internal loopback serial bit, registered |

## Verification
Suppose the slot counter loads at the wrong count. Every word boundary then moves, and the first word after reset arrives early or late by whole bits, within two word periods of reset release. A shift register that fills or resets with zeros shows up as zeros on the idle line before the first load, or in the bits after a word ends. A routing register that swaps or ignores the wrap control is visible on the bit-clock edge after the control changes. Each of these appears on `line_o` or `loop_o` at a bit period fixed by the reset release, so the bench compares every emitted bit against its expected position.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  parameter int unsigned P2S_WORD_W = 10;

  typedef enum logic {
    ROUTE_LINE = 1'b0,
    ROUTE_WRAP = 1'b1
  } p2s_route_e;
endpackage

// File: rtl/p2s_word_reg.sv
module p2s_word_reg #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= d;
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/p2s_slot_ctr.sv
module p2s_slot_ctr #(
  parameter int unsigned BITS      = 10,
  parameter int unsigned LOAD_SLOT = 9
) (
  input  logic clk,
  input  logic rst,
  output logic load_o
);
  localparam int unsigned CW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (cnt == CW'(BITS - 1)) cnt <= '0;
    else                           cnt <= cnt + CW'(1);
  end

  assign load_o = (cnt == CW'(LOAD_SLOT));

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(BITS));
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && (cnt == CW'(BITS - 1))) |-> (cnt == '0));
endmodule

// File: rtl/p2s_shifter.sv
module p2s_shifter #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)       sh <= '1;
    else if (load) sh <= word_in;
    else           sh <= {1'b1, sh[WORD_W-1:1]};
  end

  assign bit_o = sh[0];

  assert_load_word_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && load) |-> (sh == $past(word_in)));
  assert_lsb_advance_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load) |-> (sh[0] == $past(sh[1])));
endmodule

// File: rtl/p2s_route.sv
module p2s_route
  import p2s_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wrap_en,
  input  logic ser_bit,
  output logic line_o,
  output logic loop_o
);
  p2s_route_e route;

  always_comb route = wrap_en ? ROUTE_WRAP : ROUTE_LINE;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= 1'b1;
      loop_o <= 1'b1;
    end else begin
      case (route)
        ROUTE_WRAP: begin
          line_o <= 1'b1;
          loop_o <= ser_bit;
        end
        default: begin
          line_o <= ser_bit;
          loop_o <= 1'b1;
        end
      endcase
    end
  end

  assert_line_high_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wrap_en) |-> line_o);
  assert_loop_data_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wrap_en) |-> (loop_o == $past(ser_bit)));
  assert_loop_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wrap_en) |-> loop_o);
  assert_line_data_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wrap_en) |-> (line_o == $past(ser_bit)));
endmodule

// File: rtl/par2ser_tx.sv
module par2ser_tx #(
  parameter int unsigned WORD_W    = p2s_pkg::P2S_WORD_W,
  parameter int unsigned LOAD_SLOT = WORD_W - 1
) (
  input  logic              word_clk,
  input  logic              bit_clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              wrap_en,
  output logic              line_o,
  output logic              loop_o
);
  logic [WORD_W-1:0] word_q;
  logic              load;
  logic              ser_bit;

  p2s_word_reg #(.WORD_W(WORD_W)) u_cap (
    .clk (word_clk),
    .rst (rst),
    .d   (tx_word),
    .q   (word_q)
  );

  p2s_slot_ctr #(.BITS(WORD_W), .LOAD_SLOT(LOAD_SLOT)) u_slot (
    .clk    (bit_clk),
    .rst    (rst),
    .load_o (load)
  );

  p2s_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (bit_clk),
    .rst     (rst),
    .load    (load),
    .word_in (word_q),
    .bit_o   (ser_bit)
  );

  p2s_route u_route (
    .clk     (bit_clk),
    .rst     (rst),
    .wrap_en (wrap_en),
    .ser_bit (ser_bit),
    .line_o  (line_o),
    .loop_o  (loop_o)
  );

  assert_idle_pair_R5: assert property (@(posedge bit_clk) disable iff (rst)
    (line_o || loop_o));
endmodule

// File: tb/sim_par2ser_tx.sv
module sim_par2ser_tx;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 10;

  logic              word_clk = 1'b0;
  logic              bit_clk  = 1'b0;
  logic              rst      = 1'b1;
  logic [WORD_W-1:0] tx_word  = '0;
  logic              wrap_en  = 1'b0;
  logic              line_o;
  logic              loop_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  par2ser_tx u0 (
    .word_clk (word_clk),
    .bit_clk  (bit_clk),
    .rst      (rst),
    .tx_word  (tx_word),
    .wrap_en  (wrap_en),
    .line_o   (line_o),
    .loop_o   (loop_o)
  );

  always #(CLK_PERIOD / 2)       bit_clk  = ~bit_clk;
  always #(CLK_PERIOD * 5)       word_clk = ~word_clk;

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", what, $time, act, exp);
    end
  endtask

  // R5: outputs high during reset and until the first load
  task automatic t_reset_idle();
    #(CLK_PERIOD * 20);
    check(line_o, 1'b1, "R5 line in reset");
    check(loop_o, 1'b1, "R5 loop in reset");
    #(CLK_PERIOD * 10 + 2) rst = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge bit_clk);
      check(line_o, 1'b1, "R5 idle line before first load");
      check(loop_o, 1'b1, "R5 idle loop before first load");
    end
  endtask

  // R1 R2 R3 R4 R6 R7 R8 R9: stream four words and check every bit slot
  task automatic t_stream(input logic [WORD_W-1:0] w [4], input logic wr,
                          input string tag);
    @(negedge word_clk);
    wrap_en = wr;
    fork
      begin
        for (int i = 0; i < 4; i++) begin
          if (i != 0) @(negedge word_clk);
          tx_word = w[i];
          #(CLK_PERIOD * 7) tx_word = ~w[i];  // R1: ignored after capture
        end
      end
      begin
        #1;
        @(negedge bit_clk);
        if (wr) check(line_o, 1'b1, {tag, " R9 line forced on wrap change"});
        else    check(loop_o, 1'b1, {tag, " R9 loop idle on wrap change"});
        repeat (10) @(negedge bit_clk);
        for (int i = 0; i < 4; i++) begin
          for (int k = 0; k < WORD_W; k++) begin
            if (i != 0 || k != 0) @(negedge bit_clk);
            if (wr) begin
              check(line_o, 1'b1,    {tag, " R6 line held high"});
              check(loop_o, w[i][k], {tag, " R7 R3 R2 R4 R1 loop bit"});
            end else begin
              check(line_o, w[i][k], {tag, " R8 R3 R2 R4 R1 line bit"});
              check(loop_o, 1'b1,    {tag, " R8 loop idle"});
            end
          end
        end
      end
    join
    #1;
  endtask

  initial begin
    logic [WORD_W-1:0] s1 [4] = '{10'h001, 10'h200, 10'h2AA, 10'h155};
    logic [WORD_W-1:0] s2 [4] = '{10'h07C, 10'h383, 10'h3FF, 10'h000};
    logic [WORD_W-1:0] s3 [4] = '{10'h0F0, 10'h30F, 10'h1E3, 10'h2C5};
    logic [WORD_W-1:0] s4 [4] = '{10'h3C1, 10'h03E, 10'h249, 10'h1B6};
    t_reset_idle();
    t_stream(s1, 1'b0, "line_walk");
    t_stream(s2, 1'b1, "wrap_a");
    t_stream(s3, 1'b0, "line_back");
    t_stream(s4, 1'b1, "wrap_b");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule